// File: doc/BRIEF.md
# Three-Phase Gate-Drive Protection Logic

This block is the synchronous logic between a motor controller's six PWM commands and the six gate enables of a three-phase half-bridge. Each phase has a high and a low command, and each phase gets a high and a low gate enable. An interlock passes a gate only when its own command is the only one asserted in that phase. Dead time is not added here. The controller still has to provide it.

Four sources can take gates away. The first is a digitised overcurrent flag. It must pass a blanking filter before it trips. Once tripped, all gates are held off and an active-low fault output is driven for a timed, non-latching recovery. The second is a logic-supply undervoltage flag, and the third is an active-high enable input. Both of these remove every gate only while they are present. The last is a per-phase high-side supply undervoltage flag. It removes only that phase's high gate, and it keeps the gate blocked until the high command has been seen low.

Every asynchronous input passes through a two-flop synchroniser. The blanking and recovery intervals are parameters counted in clock cycles.

Top module: `phase_gate_guard`

## Requirements
- R1: Per phase, the high gate is 1 only for commands high=1, low=0. The low gate is 1 only for high=0, low=1. Commands 1/1 or 0/0 give both gates 0.
- R2: While an overcurrent trip is active, all high and low gates are 0 and `fault_n` is 0. With no trip, `fault_n` is 1.
- R3: An overcurrent pulse seen for fewer than `BLANK_CYC` consecutive clock cycles causes no trip. One held for `BLANK_CYC + 4` cycles has tripped.
- R4: The trip does not latch. After the overcurrent flag drops, `fault_n` is still 0 at `RECOV_CYC + 2` clock edges. It is 1 at `RECOV_CYC + 5` edges, and the gates follow the commands again.
- R5: An overcurrent flag seen during recovery restarts the recovery interval from its next release, and `fault_n` stays 0 throughout.
- R6: A logic-supply undervoltage flag forces all six gates to 0. Gating resumes as soon as the flag clears, with no command condition.
- R7: A high-side undervoltage flag on one phase forces only that phase's high gate to 0. Low gates and the other phases are not affected.
- R8: After a phase's high-side undervoltage flag clears, its high gate stays 0 while its high command remains 1. The gate returns only after that command has been seen at 0.
- R9: `enable` at 0 forces all gates to 0 while it is held. It does not change `fault_n`.
- R10: Reset drives all gates to 0 and `fault_n` to 1. After reset, a high gate turns on only after its high command has been seen at 0.
- R11: A command change reaches the gate outputs on the third rising clock edge after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| hi_cmd | input | NPH | High-side PWM command per phase (bit 0 = first phase) |
| lo_cmd | input | NPH | Low-side PWM command per phase |
| ocp_flag | input | 1 | Overcurrent comparator output, active high |
| enable | input | 1 | Gate enable; 0 shuts all gates |
| logic_uv | input | 1 | Logic-supply undervoltage, active high |
| hs_uv | input | NPH | High-side supply undervoltage per phase, active high |
| hi_gate | output | NPH | High gate enables |
| lo_gate | output | NPH | Low gate enables |
| fault_n | output | 1 | Overcurrent fault indication, active low |

## Verification
Suppose a high-side lockout bit is stuck or is cleared at the wrong time. A high gate then stays dark after a released undervoltage, or it lights three edges after the supply recovers while its command is still high. The vector table exposes both cases.

A wrong trip counter changes when `fault_n` returns. The bench brackets that edge to within three clocks. A blanking filter that is off by one shows up as a fault from a pulse one cycle short of the threshold.

An interlock slip appears as a gate enabled with both commands set. That happens three edges after the commands are applied.

// File: rtl/gguard_pkg.sv
package gguard_pkg;

    typedef enum logic [1:0] {
        TRIP_IDLE    = 2'd0,
        TRIP_HOLD    = 2'd1,
        TRIP_RECOVER = 2'd2
    } trip_state_t;

    typedef struct packed {
        logic lock;
        logic hi;
        logic lo;
    } phase_reg_t;

endpackage

// File: rtl/gguard_sync.sv
module gguard_sync #(
    parameter int           W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stable;
    } sync_reg_t;

    sync_reg_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.meta   = d;
        s_d.stable = s_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{meta: RST_VAL, stable: RST_VAL};
        end else begin
            s_q <= s_d;
        end
    end

    assign q = s_q.stable;

endmodule

// File: rtl/gguard_trip.sv
module gguard_trip
    import gguard_pkg::*;
#(
    parameter int BLANK_CYC = 35,
    parameter int RECOV_CYC = 200000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ocp_s,
    output logic trip_active
);

    localparam int BLK_W = (BLANK_CYC > 1) ? $clog2(BLANK_CYC) : 1;
    localparam int REC_W = (RECOV_CYC > 1) ? $clog2(RECOV_CYC) : 1;
    localparam logic [BLK_W-1:0] BLK_LAST = BLK_W'(BLANK_CYC - 1);
    localparam logic [REC_W-1:0] REC_LAST = REC_W'(RECOV_CYC - 1);

    typedef struct packed {
        trip_state_t      st;
        logic [BLK_W-1:0] blk;
        logic [REC_W-1:0] rec;
    } trip_reg_t;

    trip_reg_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        unique case (t_q.st)
            TRIP_IDLE: begin
                if (ocp_s) begin
                    if (t_q.blk == BLK_LAST) begin
                        t_d.st  = TRIP_HOLD;
                        t_d.blk = '0;
                    end else begin
                        t_d.blk = t_q.blk + 1'b1;
                    end
                end else begin
                    t_d.blk = '0;
                end
            end
            TRIP_HOLD: begin
                if (!ocp_s) begin
                    t_d.st  = TRIP_RECOVER;
                    t_d.rec = '0;
                end
            end
            TRIP_RECOVER: begin
                if (ocp_s) begin
                    t_d.st  = TRIP_HOLD;
                    t_d.rec = '0;
                end else if (t_q.rec == REC_LAST) begin
                    t_d.st  = TRIP_IDLE;
                    t_d.rec = '0;
                end else begin
                    t_d.rec = t_q.rec + 1'b1;
                end
            end
            default: begin
                t_d = '{st: TRIP_IDLE, blk: '0, rec: '0};
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '{st: TRIP_IDLE, blk: '0, rec: '0};
        end else begin
            t_q <= t_d;
        end
    end

    assign trip_active = (t_q.st != TRIP_IDLE);

    // R3: a trip starts only after the blanking count has been filled
    assert_blank_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (t_q.st == TRIP_HOLD && $past(t_q.st) == TRIP_IDLE)
            |-> $past(ocp_s && t_q.blk == BLK_LAST));

    // R4: leaving recovery needs the full recovery count
    assert_recov_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (t_q.st == TRIP_IDLE && $past(t_q.st) == TRIP_RECOVER)
            |-> $past(!ocp_s && t_q.rec == REC_LAST));

    // R5: overcurrent during recovery returns to hold
    assert_recov_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (t_q.st == TRIP_RECOVER && ocp_s) |=> (t_q.st == TRIP_HOLD));

endmodule

// File: rtl/gguard_phase.sv
module gguard_phase
    import gguard_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hi_s,
    input  logic lo_s,
    input  logic hs_uv_s,
    input  logic global_off,
    output logic hi_gate,
    output logic lo_gate
);

    phase_reg_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        if (hs_uv_s) begin
            p_d.lock = 1'b1;
        end else if (!hi_s) begin
            p_d.lock = 1'b0;
        end
        p_d.hi = hi_s & ~lo_s & ~p_q.lock & ~hs_uv_s & ~global_off;
        p_d.lo = lo_s & ~hi_s & ~global_off;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q <= '{lock: 1'b1, hi: 1'b0, lo: 1'b0};
        end else begin
            p_q <= p_d;
        end
    end

    assign hi_gate = p_q.hi;
    assign lo_gate = p_q.lo;

    // R1: a gate is on only after its exclusive command
    assert_hi_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
        p_q.hi |-> $past(hi_s && !lo_s));
    assert_lo_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
        p_q.lo |-> $past(lo_s && !hi_s));

    // R7: high-side undervoltage blocks this high gate
    assert_hs_uv_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hs_uv_s |=> !p_q.hi);

    // R8: lockout releases only with a low command and no undervoltage
    assert_lock_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(p_q.lock) |-> $past(!hi_s && !hs_uv_s));

endmodule

// File: rtl/phase_gate_guard.sv
module phase_gate_guard #(
    parameter int NPH       = 3,
    parameter int BLANK_CYC = 35,
    parameter int RECOV_CYC = 200000
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NPH-1:0] hi_cmd,
    input  logic [NPH-1:0] lo_cmd,
    input  logic           ocp_flag,
    input  logic           enable,
    input  logic           logic_uv,
    input  logic [NPH-1:0] hs_uv,
    output logic [NPH-1:0] hi_gate,
    output logic [NPH-1:0] lo_gate,
    output logic           fault_n
);

    localparam int SW = 3 * NPH + 3;
    localparam logic [SW-1:0] SYNC_RST =
        {{NPH{1'b0}}, {NPH{1'b0}}, {NPH{1'b1}}, 1'b0, 1'b0, 1'b1};

    logic [SW-1:0]  raw_bus, sync_bus;
    logic [NPH-1:0] hi_s, lo_s, hs_uv_s;
    logic           ocp_s, en_s, luv_s;
    logic           trip_active, global_off;

    typedef struct packed {
        logic fault_n;
    } top_reg_t;

    top_reg_t r_d, r_q;

    assign raw_bus = {hi_cmd, lo_cmd, hs_uv, ocp_flag, enable, logic_uv};

    gguard_sync #(.W(SW), .RST_VAL(SYNC_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_bus),
        .q     (sync_bus)
    );

    assign {hi_s, lo_s, hs_uv_s, ocp_s, en_s, luv_s} = sync_bus;

    gguard_trip #(.BLANK_CYC(BLANK_CYC), .RECOV_CYC(RECOV_CYC)) u_trip (
        .clk         (clk),
        .rst_n       (rst_n),
        .ocp_s       (ocp_s),
        .trip_active (trip_active)
    );

    assign global_off = trip_active | luv_s | ~en_s;

    for (genvar g = 0; g < NPH; g++) begin : g_phase
        gguard_phase u_phase (
            .clk        (clk),
            .rst_n      (rst_n),
            .hi_s       (hi_s[g]),
            .lo_s       (lo_s[g]),
            .hs_uv_s    (hs_uv_s[g]),
            .global_off (global_off),
            .hi_gate    (hi_gate[g]),
            .lo_gate    (lo_gate[g])
        );
    end

    always_comb begin
        r_d         = r_q;
        r_d.fault_n = ~trip_active;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{fault_n: 1'b1};
        end else begin
            r_q <= r_d;
        end
    end

    assign fault_n = r_q.fault_n;

    // R2: an active trip clears all gates and flags the fault
    assert_trip_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        trip_active |=> (hi_gate == '0 && lo_gate == '0 && !fault_n));

    // R6: logic-supply undervoltage clears all gates
    assert_luv_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        luv_s |=> (hi_gate == '0 && lo_gate == '0));

    // R9: disable clears all gates
    assert_en_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !en_s |=> (hi_gate == '0 && lo_gate == '0));

endmodule

// File: tb/phase_gate_guard_tb.sv
module phase_gate_guard_tb;

    localparam int CLK_P = 10;
    localparam int NPH   = 3;
    localparam int BLANK = 8;
    localparam int RECOV = 40;
    localparam int NVEC  = 14;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [NPH-1:0] hi_cmd, lo_cmd, hs_uv;
    logic           ocp_flag, enable, logic_uv;
    logic [NPH-1:0] hi_gate, lo_gate;
    logic           fault_n;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    // hi, lo, en, luv, huv, exp_hi, exp_lo
    localparam logic [16:0] VEC [NVEC] = '{
        {3'b000, 3'b000, 1'b1, 1'b0, 3'b000, 3'b000, 3'b000},
        {3'b001, 3'b010, 1'b1, 1'b0, 3'b000, 3'b001, 3'b010},
        {3'b011, 3'b110, 1'b1, 1'b0, 3'b000, 3'b001, 3'b100},
        {3'b111, 3'b000, 1'b1, 1'b0, 3'b000, 3'b111, 3'b000},
        {3'b111, 3'b000, 1'b1, 1'b0, 3'b010, 3'b101, 3'b000},
        {3'b111, 3'b000, 1'b1, 1'b0, 3'b000, 3'b101, 3'b000},
        {3'b101, 3'b010, 1'b1, 1'b0, 3'b000, 3'b101, 3'b010},
        {3'b111, 3'b000, 1'b1, 1'b0, 3'b000, 3'b111, 3'b000},
        {3'b100, 3'b011, 1'b1, 1'b0, 3'b100, 3'b000, 3'b011},
        {3'b000, 3'b011, 1'b1, 1'b0, 3'b000, 3'b000, 3'b011},
        {3'b001, 3'b110, 1'b1, 1'b1, 3'b000, 3'b000, 3'b000},
        {3'b001, 3'b110, 1'b1, 1'b0, 3'b000, 3'b001, 3'b110},
        {3'b001, 3'b110, 1'b0, 1'b0, 3'b000, 3'b000, 3'b000},
        {3'b001, 3'b110, 1'b1, 1'b0, 3'b000, 3'b001, 3'b110}
    };

    function automatic string vec_tag(input int i);
        case (i)
            4, 8:    return "R7";
            5, 6, 7: return "R8";
            10, 11:  return "R6";
            12, 13:  return "R9";
            default: return "R1";
        endcase
    endfunction

    phase_gate_guard #(.NPH(NPH), .BLANK_CYC(BLANK), .RECOV_CYC(RECOV)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .hi_cmd   (hi_cmd),
        .lo_cmd   (lo_cmd),
        .ocp_flag (ocp_flag),
        .enable   (enable),
        .logic_uv (logic_uv),
        .hs_uv    (hs_uv),
        .hi_gate  (hi_gate),
        .lo_gate  (lo_gate),
        .fault_n  (fault_n)
    );

    always #(CLK_P / 2) clk = ~clk;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic edges(input int n);
        for (int k = 0; k < n; k++) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; hi_cmd = '0; lo_cmd = '0; hs_uv = '0;
        ocp_flag = 1'b0; enable = 1'b1; logic_uv = 1'b0;
        edges(3);
        chk("R10", "reset hi", hi_gate, 3'b000);
        chk("R10", "reset lo", lo_gate, 3'b000);
        chk("R10", "reset fault", fault_n, 1'b1);
        rst_n = 1'b1;
        edges(4);

        // vector table walk
        for (int i = 0; i < NVEC; i++) begin
            {hi_cmd, lo_cmd, enable, logic_uv, hs_uv} = VEC[i][16:6];
            edges(4);
            chk(vec_tag(i), $sformatf("vec%0d hi", i), hi_gate, VEC[i][5:3]);
            chk(vec_tag(i), $sformatf("vec%0d lo", i), lo_gate, VEC[i][2:0]);
            chk(vec_tag(i), $sformatf("vec%0d fault", i), fault_n, 1'b1);
        end

        // R11 latency: lo command of phase 1 drops
        lo_cmd = 3'b100;
        edges(2);
        chk("R11", "before third edge", lo_gate, 3'b110);
        edges(1);
        chk("R11", "at third edge", lo_gate, 3'b100);

        // R3: pulse one cycle short of blanking
        hi_cmd = 3'b001; lo_cmd = 3'b000;
        edges(4);
        ocp_flag = 1'b1;
        edges(BLANK - 1);
        ocp_flag = 1'b0;
        for (int k = 0; k < 12; k++) begin
            edges(1);
            chk("R3", "short pulse fault", fault_n, 1'b1);
            chk("R3", "short pulse hi", hi_gate, 3'b001);
        end

        // R2/R3: long pulse trips
        ocp_flag = 1'b1;
        edges(BLANK + 4);
        chk("R3", "long pulse trips", fault_n, 1'b0);
        chk("R2", "trip hi off", hi_gate, 3'b000);
        chk("R2", "trip lo off", lo_gate, 3'b000);

        // R4: timed recovery
        ocp_flag = 1'b0;
        edges(RECOV + 2);
        chk("R4", "still recovering", fault_n, 1'b0);
        chk("R4", "gates held", hi_gate, 3'b000);
        edges(3);
        chk("R4", "recovered fault", fault_n, 1'b1);
        chk("R4", "recovered hi", hi_gate, 3'b001);

        // R5: re-assert during recovery
        ocp_flag = 1'b1;
        edges(BLANK + 4);
        ocp_flag = 1'b0;
        edges(RECOV / 2);
        ocp_flag = 1'b1;
        edges(2);
        ocp_flag = 1'b0;
        edges(RECOV + 2);
        chk("R5", "restarted timer fault", fault_n, 1'b0);
        chk("R5", "restarted timer hi", hi_gate, 3'b000);
        edges(3);
        chk("R5", "after restart fault", fault_n, 1'b1);
        chk("R5", "after restart hi", hi_gate, 3'b001);

        // R10: mid-run reset with high commands held
        hi_cmd = 3'b111; lo_cmd = 3'b000;
        edges(4);
        rst_n = 1'b0;
        edges(1);
        chk("R10", "in reset hi", hi_gate, 3'b000);
        chk("R10", "in reset fault", fault_n, 1'b1);
        rst_n = 1'b1;
        edges(5);
        chk("R10", "locked after reset", hi_gate, 3'b000);
        hi_cmd = 3'b000;
        edges(4);
        hi_cmd = 3'b111;
        edges(4);
        chk("R10", "unlocked after low cmd", hi_gate, 3'b111);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule